// File: doc/BRIEF.md
# Two-parallel symmetric FIR filter

This block filters one real sample stream at two samples per clock. Each valid clock it takes an even-indexed sample and the following odd-indexed sample. It returns the two matching filter outputs, three clocks later. The impulse response is fixed at elaboration and must be even-symmetric with an even number of taps N. Only the first N/2 taps are given. The second half is their mirror image.

The two polyphase branches are combined into a sum branch and a difference branch. Because the impulse response is mirrored, the odd polyphase set is the reverse of the even set. The sum sub-filter therefore has symmetric taps and the difference sub-filter has antisymmetric taps. Both sub-filters add or subtract each mirrored pair of delayed inputs before a single shared multiply. A third, plain sub-filter applies the odd polyphase taps to the odd input. It supplies the cross term, which is removed once and added back one block later. The post-adders form the sum and the difference of the two folded sub-filter outputs. An exact arithmetic halving then restores the scale.

Top module: `fir2p_symconv`

## Requirements
- R1: On every valid output, `y1` equals the sum over i in 0..N-1 of h(i)·x(2k+1−i). Here x(2k) and x(2k+1) are the `x0` and `x1` of block k, and samples before the last reset count as zero.
- R2: On every valid output, `y0` equals the sum over i of h(i)·x(2k−i), using the same sample numbering as R1.
- R3: `HALF_COEFS` carries h(0)..h(N/2−1), with h(i) in bits [i·CW +: CW], two's complement. h(N−1−i) equals h(i). The filter is correct whether N/2 is even or odd. When N/2 is odd there is an unpaired middle tap, and the difference sub-filter's middle coefficient is zero.
- R4: The halving of the post-adder sum and difference loses no bit. Both bracketed results are even for every input pattern.
- R5: A block accepted with `in_valid` high at a rising edge appears on `y0`/`y1` with `out_valid` high after the third rising edge, counting the accepting edge as the first. `out_valid` is low for every other cycle.
- R6: While `in_valid` is low, `x0`/`x1` are ignored and the delay lines hold. `out_valid` goes low and `y0`/`y1` keep their last values three clocks later. The valid blocks on either side of a gap are filtered as one contiguous stream.
- R7: A synchronous active-low `rst_n` clears every delay line and the carried cross term. After reset, `out_valid`, `y0` and `y1` read zero, and later outputs show no trace of earlier samples.
- R8: Outputs are OW = DW+CW+clog2(N)+1 bits, two's complement. Full-scale inputs, including the most negative code, never overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Block present on `x0`/`x1` |
| x0 | input | DW | Even-indexed sample, signed |
| x1 | input | DW | Odd-indexed sample, signed |
| out_valid | output | 1 | `y0`/`y1` carry a new block |
| y0 | output | OW | Even-indexed output, signed |
| y1 | output | OW | Odd-indexed output, signed |

## Verification
The one-block-late cross term can meet an input gap in the same cycle. The post stage then adds back the cross term of the previous valid block while idle cycles pass through the pipeline. That term must come from the last accepted block, not from a zero or a repeated value. The bench provokes this with random `in_valid` gaps, with random data driven during the gaps. It judges every output against a serial convolution over the accepted samples only, and separately against a polyphase reconstruction. It also checks an exhaustive sweep of all input pairs, with mirrored tap sets of odd and even half-length.

// File: rtl/fir2p_pkg.sv
// Shared types and width helpers for the two-parallel symmetric FIR.
package fir2p_pkg;

    // How a sub-filter treats its taps.
    typedef enum logic [1:0] {
        SF_PLAIN = 2'd0,   // one multiplier per tap
        SF_SYM   = 2'd1,   // mirrored taps added before a shared multiply
        SF_ANTI  = 2'd2    // mirrored taps subtracted before a shared multiply
    } sf_mode_e;

    // Accumulator width of a sub-filter: input width iw, coefficient width cw,
    // m taps; one bit for the pre-fold, one for sign headroom.
    function automatic int sub_width(int iw, int cw, int m);
        return iw + cw + 1 + $clog2(m) + 1;
    endfunction

endpackage

// File: rtl/fir2p_delay_line.sv
// Tapped delay line. Tap j holds the value written j accepted blocks ago,
// tap 0 being the most recent. Shifts only when en is high.
// Assumes DEPTH >= 1.
module fir2p_delay_line #(
    parameter int W     = 5,
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [W-1:0]       d,
    output logic [DEPTH*W-1:0] taps
);

    logic [W-1:0] stage [DEPTH];

    // Shift register: load tap 0, move the rest down; reset clears all taps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) stage[j] <= '0;
        end else if (en) begin
            stage[0] <= d;
            for (int j = 1; j < DEPTH; j++) stage[j] <= stage[j-1];
        end
    end

    for (genvar j = 0; j < DEPTH; j++) begin : g_tap
        assign taps[j*W +: W] = stage[j];
    end

    // Idle cycles leave the newest tap untouched.
    p_hold_on_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(stage[0]));

    if (DEPTH > 1) begin : g_shift_chk
        // An accepted block pushes the previous newest value one tap down.
        p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
            en |=> stage[1] == $past(stage[0]));
    end

endmodule

// File: rtl/fir2p_subfilter.sv
// Length-M FIR sub-filter with a registered output.
// MODE SF_PLAIN multiplies every tap. SF_SYM and SF_ANTI assume
// coefficient j equals (+/-) coefficient M-1-j. They add (or subtract)
// the two mirrored taps first and use one multiplier per pair. An odd
// middle tap gets its own product; for SF_ANTI its coefficient is zero.
// COEFS holds coefficient j at [j*CFW +: CFW], signed.
module fir2p_subfilter
    import fir2p_pkg::*;
#(
    parameter int               IW    = 5,
    parameter int               CFW   = 5,
    parameter int               M     = 4,
    parameter int               SW    = 16,
    parameter sf_mode_e         MODE  = SF_SYM,
    parameter logic [M*CFW-1:0] COEFS = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [M*IW-1:0]       taps,
    output logic signed [SW-1:0]  acc_q
);

    localparam int PW    = IW + 1;
    localparam int PRW   = PW + CFW;
    localparam int PAIRS = M / 2;
    localparam int NPROD = (MODE == SF_PLAIN) ? M : (M + 1) / 2;

    logic signed [PRW-1:0] prod [NPROD];
    logic signed [SW-1:0]  acc_d;

    if (MODE == SF_PLAIN) begin : g_plain
        for (genvar j = 0; j < M; j++) begin : g_tap
            localparam logic signed [CFW-1:0] CF = COEFS[j*CFW +: CFW];
            logic signed [IW-1:0] a;
            assign a       = taps[j*IW +: IW];
            assign prod[j] = PRW'(a) * PRW'(CF);
        end
    end else begin : g_fold
        for (genvar j = 0; j < PAIRS; j++) begin : g_pair
            localparam logic signed [CFW-1:0] CF = COEFS[j*CFW +: CFW];
            logic signed [IW-1:0] a, b;
            logic signed [PW-1:0] folded;
            assign a = taps[j*IW +: IW];
            assign b = taps[(M-1-j)*IW +: IW];
            if (MODE == SF_ANTI) begin : g_sub
                assign folded = PW'(a) - PW'(b);
            end else begin : g_add
                assign folded = PW'(a) + PW'(b);
            end
            assign prod[j] = PRW'(folded) * PRW'(CF);
        end
        if ((M % 2) == 1) begin : g_mid
            localparam logic signed [CFW-1:0] CF = COEFS[PAIRS*CFW +: CFW];
            logic signed [IW-1:0] m;
            assign m           = taps[PAIRS*IW +: IW];
            assign prod[PAIRS] = PRW'(m) * PRW'(CF);
        end
    end

    // Adder tree over all products.
    always_comb begin
        acc_d = '0;
        for (int j = 0; j < NPROD; j++) acc_d += SW'(prod[j]);
    end

    // Output register, loaded once per accepted block.
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= acc_d;
    end

endmodule

// File: rtl/fir2p_post.sv
// Post-adders and halving. a is the sum sub-filter, b the difference
// sub-filter, c the plain cross-term sub-filter, all for the same block.
// y1 = (a-b)/2, y0 = (a+b)/2 - c + c_of_previous_block.
// Assumes a+b and a-b are even (true for mirrored coefficients).
module fir2p_post #(
    parameter int SW = 16,
    parameter int OW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [SW-1:0] a,
    input  logic signed [SW-1:0] b,
    input  logic signed [SW-1:0] c,
    output logic                 out_valid,
    output logic signed [OW-1:0] y0,
    output logic signed [OW-1:0] y1
);

    localparam int TW = SW + 2;

    logic signed [TW-1:0] sum_ab, dif_ab, half_s, half_d, c_prev, y0_full;
    logic signed [OW-1:0] y0_trunc, y1_trunc;

    assign sum_ab   = TW'(a) + TW'(b);
    assign dif_ab   = TW'(a) - TW'(b);
    assign half_s   = sum_ab >>> 1;
    assign half_d   = dif_ab >>> 1;
    assign y0_full  = half_s - TW'(c) + c_prev;
    assign y0_trunc = OW'(y0_full);
    assign y1_trunc = OW'(half_d);

    // Output and carried cross-term registers, advanced per accepted block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y0        <= '0;
            y1        <= '0;
            c_prev    <= '0;
        end else begin
            out_valid <= en;
            if (en) begin
                y0     <= y0_trunc;
                y1     <= y1_trunc;
                c_prev <= TW'(c);
            end
        end
    end

    // Sum and difference of the two folded sub-filters are even.
    p_exact_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (!sum_ab[0] && !dif_ab[0]));

    // Narrowing to the port width never drops significant bits.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (y0_full == TW'(y0_trunc) && half_d == TW'(y1_trunc)));

    // Idle blocks keep the outputs frozen.
    p_outputs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(y0) && $stable(y1)));

endmodule

// File: rtl/fir2p_symconv.sv
// Two-parallel FIR for an even-symmetric, even-length impulse response.
// Pre-adds the two input phases into sum and difference streams and delays
// them together with the odd phase. Runs two folded sub-filters and one plain
// sub-filter, then combines and halves. Latency is three clocks on every path.
// Assumes NTAPS even and >= 2; HALF_COEFS holds h(0)..h(NTAPS/2-1).
module fir2p_symconv
    import fir2p_pkg::*;
#(
    parameter int                     DW         = 4,
    parameter int                     CW         = 4,
    parameter int                     NTAPS      = 8,
    parameter logic [NTAPS/2*CW-1:0]  HALF_COEFS = 16'h87B3,
    localparam int                    OW         = DW + CW + $clog2(NTAPS) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x0,
    input  logic signed [DW-1:0] x1,
    output logic                 out_valid,
    output logic signed [OW-1:0] y0,
    output logic signed [OW-1:0] y1
);

    localparam int M   = NTAPS / 2;
    localparam int XW  = DW + 1;
    localparam int SFW = CW + 1;
    localparam int SW  = sub_width(XW, SFW, M);

    // Full impulse response tap i, mirrored from the stored half.
    function automatic logic signed [CW-1:0] tap_coef(int i);
        int k;
        k = (i < M) ? i : NTAPS - 1 - i;
        return HALF_COEFS[k*CW +: CW];
    endfunction

    // Sum (anti=0) or difference (anti=1) of the two polyphase sets.
    function automatic logic [M*SFW-1:0] build_fold(bit anti);
        logic [M*SFW-1:0]     v;
        logic signed [SFW-1:0] e, o;
        v = '0;
        for (int j = 0; j < M; j++) begin
            e = tap_coef(2*j);
            o = tap_coef(2*j + 1);
            v[j*SFW +: SFW] = anti ? (e - o) : (e + o);
        end
        return v;
    endfunction

    // Odd polyphase set.
    function automatic logic [M*CW-1:0] build_odd();
        logic [M*CW-1:0] v;
        v = '0;
        for (int j = 0; j < M; j++) v[j*CW +: CW] = tap_coef(2*j + 1);
        return v;
    endfunction

    localparam logic [M*SFW-1:0] SUM_COEFS = build_fold(1'b0);
    localparam logic [M*SFW-1:0] DIF_COEFS = build_fold(1'b1);
    localparam logic [M*CW-1:0]  ODD_COEFS = build_odd();

    logic signed [XW-1:0] xs_d, xd_d;
    logic [M*XW-1:0]      xs_taps, xd_taps;
    logic [M*DW-1:0]      x1_taps;
    logic signed [SW-1:0] acc_sum, acc_dif, acc_odd;
    logic                 v1, v2;

    assign xs_d = XW'(x0) + XW'(x1);
    assign xd_d = XW'(x0) - XW'(x1);

    // Valid tracking through the delay-line and sub-filter stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
        end
    end

    fir2p_delay_line #(.W(XW), .DEPTH(M)) u_dl_sum (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .d(xs_d), .taps(xs_taps));

    fir2p_delay_line #(.W(XW), .DEPTH(M)) u_dl_dif (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .d(xd_d), .taps(xd_taps));

    fir2p_delay_line #(.W(DW), .DEPTH(M)) u_dl_odd (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .d(x1), .taps(x1_taps));

    fir2p_subfilter #(.IW(XW), .CFW(SFW), .M(M), .SW(SW),
                      .MODE(SF_SYM), .COEFS(SUM_COEFS)) u_sf_sum (
        .clk(clk), .rst_n(rst_n), .en(v1), .taps(xs_taps), .acc_q(acc_sum));

    fir2p_subfilter #(.IW(XW), .CFW(SFW), .M(M), .SW(SW),
                      .MODE(SF_ANTI), .COEFS(DIF_COEFS)) u_sf_dif (
        .clk(clk), .rst_n(rst_n), .en(v1), .taps(xd_taps), .acc_q(acc_dif));

    fir2p_subfilter #(.IW(DW), .CFW(CW), .M(M), .SW(SW),
                      .MODE(SF_PLAIN), .COEFS(ODD_COEFS)) u_sf_odd (
        .clk(clk), .rst_n(rst_n), .en(v1), .taps(x1_taps), .acc_q(acc_odd));

    fir2p_post #(.SW(SW), .OW(OW)) u_post (
        .clk(clk), .rst_n(rst_n), .en(v2),
        .a(acc_sum), .b(acc_dif), .c(acc_odd),
        .out_valid(out_valid), .y0(y0), .y1(y1));

    // A reset cycle leaves the outputs cleared and not valid.
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && y0 == '0 && y1 == '0));

endmodule

// File: tb/tb_fir2p_symconv.sv
`timescale 1ns/1ps
module tb_fir2p_symconv;

    localparam int DW  = 4;
    localparam int CW  = 4;
    localparam int NA  = 8;
    localparam int NB  = 6;
    localparam int OWA = DW + CW + $clog2(NA) + 1;
    localparam int OWB = DW + CW + $clog2(NB) + 1;
    localparam int HMAX = 4096;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic signed [DW-1:0]  x0 = '0, x1 = '0;
    logic                  va, vb;
    logic signed [OWA-1:0] y0a, y1a;
    logic signed [OWB-1:0] y0b, y1b;

    // R3: h(0..3) = 3,-5,7,-8 and h(0..2) = -8,6,-1 packed at [i*CW +: CW].
    fir2p_symconv #(.DW(DW), .CW(CW), .NTAPS(NA), .HALF_COEFS(16'h87B3)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x0(x0), .x1(x1),
        .out_valid(va), .y0(y0a), .y1(y1a));

    fir2p_symconv #(.DW(DW), .CW(CW), .NTAPS(NB), .HALF_COEFS(12'hF68)) dut_odd (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x0(x0), .x1(x1),
        .out_valid(vb), .y0(y0b), .y1(y1b));

    always #2 clk = ~clk;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;
    string phase = "init";
    int hc [2][8];
    int ntap [2];
    int hist [HMAX];
    int ns = 0;
    bit pv  [2][3];
    int py0 [2][3];
    int py1 [2][3];
    int held0 [2], held1 [2];

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
        end
    endtask

    // Serial reference: y(n) = sum h(i) x(n-i).
    function automatic int conv(int d, int n);
        int s = 0;
        for (int i = 0; i < ntap[d]; i++)
            if (n - i >= 0) s += hc[d][i] * hist[n-i];
        return s;
    endfunction

    // Polyphase reference for block k; sel 0 -> y0, 1 -> y1.
    function automatic int poly(int d, int k, int sel);
        int s = 0;
        for (int j = 0; j < ntap[d] / 2; j++) begin
            if (sel == 0) begin
                if (k - j >= 0)     s += hc[d][2*j] * hist[2*(k-j)];
                if (k - 1 - j >= 0) s += hc[d][2*j+1] * hist[2*(k-1-j)+1];
            end else if (k - j >= 0) begin
                s += hc[d][2*j] * hist[2*(k-j)+1] + hc[d][2*j+1] * hist[2*(k-j)];
            end
        end
        return s;
    endfunction

    task automatic check_dut(int d, bit av, int ay0, int ay1);
        if (pv[d][2]) begin
            chk($sformatf("R5 valid dut%0d", d), av, 1);
            chk($sformatf("R2 y0 dut%0d", d), ay0, py0[d][2]);
            chk($sformatf("R1 y1 dut%0d", d), ay1, py1[d][2]);
            held0[d] = py0[d][2];
            held1[d] = py1[d][2];
        end else begin
            chk($sformatf("R5 idle valid dut%0d", d), av, 0);
            chk($sformatf("R6 hold y0 dut%0d", d), ay0, held0[d]);
            chk($sformatf("R6 hold y1 dut%0d", d), ay1, held1[d]);
        end
    endtask

    // One clock: check outputs, advance expectation pipe, drive next block.
    task automatic step(bit v, int a, int b);
        @(negedge clk);
        check_dut(0, va, int'(y0a), int'(y1a));
        check_dut(1, vb, int'(y0b), int'(y1b));
        for (int d = 0; d < 2; d++) begin
            pv[d][2] = pv[d][1]; py0[d][2] = py0[d][1]; py1[d][2] = py1[d][1];
            pv[d][1] = pv[d][0]; py0[d][1] = py0[d][0]; py1[d][1] = py1[d][0];
            pv[d][0] = v;
        end
        if (v) begin
            hist[ns] = a;
            hist[ns+1] = b;
            for (int d = 0; d < 2; d++) begin
                py0[d][0] = conv(d, ns);
                py1[d][0] = conv(d, ns + 1);
                chk($sformatf("R2 poly-ref y0 dut%0d", d), poly(d, ns / 2, 0), py0[d][0]);
                chk($sformatf("R1 poly-ref y1 dut%0d", d), poly(d, ns / 2, 1), py1[d][0]);
            end
            ns += 2;
        end
        in_valid = v;
        x0 = DW'(a);
        x1 = DW'(b);
    endtask

    // R7: synchronous reset, then check cleared outputs.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 reset valid dut0", va, 0);
        chk("R7 reset y0 dut0", int'(y0a), 0);
        chk("R7 reset y1 dut0", int'(y1a), 0);
        chk("R7 reset valid dut1", vb, 0);
        chk("R7 reset y0 dut1", int'(y0b), 0);
        chk("R7 reset y1 dut1", int'(y1b), 0);
        ns = 0;
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 3; s++) begin
                pv[d][s] = 1'b0; py0[d][s] = 0; py1[d][s] = 0;
            end
            held0[d] = 0;
            held1[d] = 0;
        end
        rst_n = 1'b1;
    endtask

    function automatic int rnd();
        return int'($urandom_range(15)) - 8;
    endfunction

    initial begin
        int ha [8] = '{3, -5, 7, -8, -8, 7, -5, 3};
        int hb [6] = '{-8, 6, -1, -1, 6, -8};
        for (int i = 0; i < 8; i++) hc[0][i] = ha[i];
        for (int i = 0; i < 8; i++) hc[1][i] = (i < 6) ? hb[i] : 0;
        ntap[0] = NA;
        ntap[1] = NB;

        phase = "R7 power-up";
        do_reset();

        // R3: impulses on each phase read out the mirrored taps.
        phase = "R3 impulse";
        step(1, 1, 0);
        repeat (5) step(1, 0, 0);
        step(1, 0, 1);
        repeat (5) step(1, 0, 0);

        // R4: every input pair, back to back.
        phase = "R4 sweep";
        for (int a = -8; a < 8; a++)
            for (int b = -8; b < 8; b++) step(1, a, b);

        // R8: full-scale runs of both signs and alternation.
        phase = "R8 extremes";
        repeat (6) step(1, -8, -8);
        repeat (6) step(1, 7, 7);
        for (int i = 0; i < 8; i++) step(1, (i % 2) ? 7 : -8, (i % 2) ? -8 : 7);
        for (int i = 0; i < 8; i++) step(1, (i % 3) ? -8 : 7, (i % 2) ? 7 : -8);

        // R5/R6: lone blocks, then random gaps with junk data on idle cycles.
        phase = "R5 isolated";
        repeat (4) step(0, 5, -3);
        step(1, 6, -7);
        repeat (4) step(0, -8, 7);
        phase = "R6 gaps";
        for (int i = 0; i < 400; i++) step($urandom_range(1), rnd(), rnd());

        // R7: reset with full delay lines; nothing of the past may leak.
        phase = "R7 mid-run";
        repeat (6) step(1, -8, 7);
        do_reset();
        step(1, 1, 1);
        repeat (5) step(1, 0, 0);

        phase = "random";
        for (int i = 0; i < 1000; i++) step(1, rnd(), rnd());
        repeat (4) step(0, 0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog R5 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule